// File: doc/BRIEF.md
# Dual H-Bridge Gate Decode and Protection Controller

This block sits between a digital PWM modulator and the gate drivers of two full bridges (four half-bridge legs). Each bridge takes a pair of logic-level PWM inputs, A and B. The block decodes the pair into enables for the bridge's four switches. Leg A has high side Q1 and low side Q3. Leg B has high side Q2 and low side Q4.

The decode is ternary-style. A zero code actively clamps both outputs to ground. The all-ones code is treated as illegal and blanks the bridge. A parallel mode drives both legs of a bridge from input A alone, so the two outputs can be tied together for twice the current.

A per-leg dead-time counter delays any turn-on whose complementary switch in the same leg is conducting. Digital flags for over-current and under-voltage are monitored, together with a temperature code in degrees Celsius. Over-current and over-temperature are latched and remove every gate at once. They stay latched until the tri-state control is pulsed low and back high. Under-voltage recovers by itself. Tri-state and power-down both hold every switch open. A thermal warning is reported ahead of shutdown.

Top module: `hb_bridge_ctrl`

## Requirements
- R1: While rst_ni is low, gate_o is all zero, fault_no is 1 and warn_no is 1.
- R2: gate_o carries four bits per bridge g, at bit 4g+0 Q1, 4g+1 Q2, 4g+2 Q3, 4g+3 Q4. With par_i low and inputs A=0, B=0, only Q3 and Q4 of that bridge are on.
- R3: With par_i low, A=0, B=1 turns on only Q2 and Q3, and A=1, B=0 turns on only Q1 and Q4.
- R4: With par_i low, A=1, B=1 is illegal and all four switches of that bridge are off one clock later.
- R5: While hiz_ni is low, every gate_o bit is 0 in the same cycle, whatever the PWM inputs.
- R6: While pwr_en_i is low, every gate_o bit is 0 in the same cycle, and fault_no is unaffected.
- R7: When a switch is requested and its leg complement is on, the complement turns off at the first clock edge and the switch turns on DEAD_CYC (default 2) edges later. When the complement is already off, the switch turns on at the first edge.
- R8: With par_i high, input B of each bridge is ignored. A=1 turns on Q1 and Q2, and A=0 turns on Q3 and Q4.
- R9: While ocp_i is high, gate_o is 0 and fault_no is low in the same cycle. The fault stays latched after ocp_i falls.
- R10: A latched fault, and the gate blanking it causes, is cleared only at a clock edge where hiz_ni is seen high after having been low at the previous edge, with no fault condition present. Switching resumes at the following edge.
- R11: A temperature code of SHUT_C (150) or more blanks all gates at once and latches the fault. The over-temperature condition holds, and blocks clearing, until the code is at or below SHUT_C minus HYST_C (125).
- R12: warn_no goes low one edge after the temperature code reaches WARN_C (130), and returns high one edge after it falls below.
- R13: While uvlo_i is high, gate_o is 0 and fault_no is low. After uvlo_i falls, switching resumes with no tri-state pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_a_i | input | NUM_BR | PWM input A per bridge |
| in_b_i | input | NUM_BR | PWM input B per bridge |
| hiz_ni | input | 1 | Tri-state control, low opens all switches; a low-high pulse clears a latched fault |
| pwr_en_i | input | 1 | Power-down control, low opens all switches |
| par_i | input | 1 | Parallel mode, both legs of a bridge follow input A |
| ocp_i | input | 1 | Over-current flag |
| uvlo_i | input | 1 | Supply under-voltage flag |
| temp_i | input | TEMP_W | Die temperature code in degrees Celsius |
| gate_o | output | 4*NUM_BR | Switch enables, Q1..Q4 per bridge |
| fault_no | output | 1 | Fault indicator, active low |
| warn_no | output | 1 | Thermal warning, active low |

## Verification
The assertions assume that the fault flags, temperature code and mode inputs are synchronous to clk_i and hold steady for a whole cycle. The combinational blanking checks compare gate_o to inputs seen in the same cycle, and would be meaningless on a glitching flag. They also assume that par_i is not changed during a dead-time window. The bench changes every input one time unit after a rising edge and samples just before the next action. It changes one control at a time, and returns to a quiet, fault-free state before each directed sequence, so that each expected value follows from a single cause.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int unsigned SW_PER_BR = 4;

  // one half-bridge leg: high-side and low-side enable
  typedef struct packed {
    logic hi;
    logic lo;
  } leg_drv_t;
endpackage

// File: rtl/hb_decode.sv
module hb_decode
  import hb_pkg::*;
(
  input  logic     a_i,
  input  logic     b_i,
  input  logic     par_i,
  output leg_drv_t leg_a_o,
  output leg_drv_t leg_b_o
);

  always_comb begin
    leg_a_o = '0;
    leg_b_o = '0;
    if (par_i) begin
      leg_a_o.hi = a_i;
      leg_a_o.lo = !a_i;
      leg_b_o    = leg_a_o;
    end else begin
      unique case ({a_i, b_i})
        2'b00: begin leg_a_o.lo = 1'b1; leg_b_o.lo = 1'b1; end
        2'b01: begin leg_a_o.lo = 1'b1; leg_b_o.hi = 1'b1; end
        2'b10: begin leg_a_o.hi = 1'b1; leg_b_o.lo = 1'b1; end
        default: ; // reserved code: bridge blanked
      endcase
    end
  end

endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  leg_drv_t want_i,
  output leg_drv_t drv_o
);

  localparam int unsigned CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] LOAD = (DEAD_CYC > 0) ? CW'(DEAD_CYC - 1) : '0;

  leg_drv_t      drv_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q <= '0;
      cnt_q <= '0;
    end else if (want_i.hi && !want_i.lo) begin
      if (drv_q.lo) begin
        drv_q.lo <= 1'b0;
        if (DEAD_CYC == 0) drv_q.hi <= 1'b1;
        else               cnt_q    <= LOAD;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
      end else begin
        drv_q.hi <= 1'b1;
      end
    end else if (want_i.lo && !want_i.hi) begin
      if (drv_q.hi) begin
        drv_q.hi <= 1'b0;
        if (DEAD_CYC == 0) drv_q.lo <= 1'b1;
        else               cnt_q    <= LOAD;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
      end else begin
        drv_q.lo <= 1'b1;
      end
    end else begin
      drv_q <= '0;
      if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign drv_o = drv_q;

  // R7
  leg_hi_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_q.hi) |-> !$past(drv_q.lo));
  // R7
  leg_lo_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_q.lo) |-> !$past(drv_q.hi));
  // R7
  leg_want_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(want_i.hi && want_i.lo));

endmodule

// File: rtl/hb_guard.sv
module hb_guard #(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned WARN_C = 130,
  parameter int unsigned SHUT_C = 150,
  parameter int unsigned HYST_C = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hiz_ni,
  input  logic              ocp_i,
  input  logic              uvlo_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              kill_o,
  output logic              warn_o
);

  localparam logic [TEMP_W-1:0] WARN_T = TEMP_W'(WARN_C);
  localparam logic [TEMP_W-1:0] SHUT_T = TEMP_W'(SHUT_C);
  localparam logic [TEMP_W-1:0] CLR_T  = TEMP_W'(SHUT_C - HYST_C);

  logic hiz_q, hot_q, latch_q, warn_q;
  logic over_shut, trip_now, hiz_rise;

  assign over_shut = (temp_i >= SHUT_T);
  assign trip_now  = ocp_i | hot_q | over_shut;
  assign hiz_rise  = hiz_ni & ~hiz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hiz_q   <= 1'b1;
      hot_q   <= 1'b0;
      latch_q <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      hiz_q  <= hiz_ni;
      warn_q <= (temp_i >= WARN_T);
      if (over_shut)           hot_q <= 1'b1;
      else if (temp_i <= CLR_T) hot_q <= 1'b0;
      if (trip_now)            latch_q <= 1'b1;
      else if (hiz_rise)       latch_q <= 1'b0;
    end
  end

  assign kill_o = latch_q | trip_now | uvlo_i;
  assign warn_o = warn_q;

  // R11
  hot_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_shut |=> hot_q);
  // R11
  hot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hot_q && temp_i > CLR_T) |=> hot_q);
  // R10
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !hiz_rise) |=> latch_q);
  // R12
  warn_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i >= WARN_T) |=> warn_q);

endmodule

// File: rtl/hb_bridge_ctrl.sv
module hb_bridge_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned NUM_BR   = 2,
  parameter int unsigned DEAD_CYC = 2,
  parameter int unsigned TEMP_W   = 8,
  parameter int unsigned WARN_C   = 130,
  parameter int unsigned SHUT_C   = 150,
  parameter int unsigned HYST_C   = 25
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_BR-1:0]           in_a_i,
  input  logic [NUM_BR-1:0]           in_b_i,
  input  logic                        hiz_ni,
  input  logic                        pwr_en_i,
  input  logic                        par_i,
  input  logic                        ocp_i,
  input  logic                        uvlo_i,
  input  logic [TEMP_W-1:0]           temp_i,
  output logic [SW_PER_BR*NUM_BR-1:0] gate_o,
  output logic                        fault_no,
  output logic                        warn_no
);

  localparam int unsigned GW = SW_PER_BR * NUM_BR;

  logic          kill, warn, run;
  logic [GW-1:0] gate_q;

  hb_guard #(
    .TEMP_W (TEMP_W),
    .WARN_C (WARN_C),
    .SHUT_C (SHUT_C),
    .HYST_C (HYST_C)
  ) u_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hiz_ni (hiz_ni),
    .ocp_i  (ocp_i),
    .uvlo_i (uvlo_i),
    .temp_i (temp_i),
    .kill_o (kill),
    .warn_o (warn)
  );

  assign run = hiz_ni & pwr_en_i & ~kill;

  for (genvar g = 0; g < NUM_BR; g++) begin : g_br
    leg_drv_t dec_a, dec_b, want_a, want_b, drv_a, drv_b;

    hb_decode u_dec (
      .a_i     (in_a_i[g]),
      .b_i     (in_b_i[g]),
      .par_i   (par_i),
      .leg_a_o (dec_a),
      .leg_b_o (dec_b)
    );

    assign want_a = run ? dec_a : '0;
    assign want_b = run ? dec_b : '0;

    hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg_a (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .want_i (want_a),
      .drv_o  (drv_a)
    );

    hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg_b (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .want_i (want_b),
      .drv_o  (drv_b)
    );

    // Q4 Q3 Q2 Q1
    assign gate_q[SW_PER_BR*g +: SW_PER_BR] = {drv_b.lo, drv_a.lo, drv_b.hi, drv_a.hi};

    // R4
    illegal_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!par_i && in_a_i[g] && in_b_i[g]) |=> (gate_o[SW_PER_BR*g +: SW_PER_BR] == '0));
  end

  // combinational blanking so a trip needs no clock edge
  assign gate_o   = gate_q & {GW{run}};
  assign fault_no = ~kill;
  assign warn_no  = ~warn;

  // R5
  hiz_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hiz_ni |-> (gate_o == '0));
  // R6
  pdn_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_i |-> (gate_o == '0));
  // R9
  ocp_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ocp_i |-> (gate_o == '0 && !fault_no));
  // R9
  ocp_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ocp_i) |-> !fault_no);
  // R13
  uvlo_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |-> (gate_o == '0 && !fault_no));

endmodule

// File: tb/hb_bridge_ctrl_test.sv
module hb_bridge_ctrl_test;

  localparam int CYC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] in_a = '0, in_b = '0;
  logic       hiz_n = 1'b1, pwr_en = 1'b1, par = 1'b0, ocp = 1'b0, uvlo = 1'b0;
  logic [7:0] temp = 8'd25;
  logic [7:0] gate;
  logic       fault_n, warn_n;
  int         n_chk = 0, n_bad = 0;

  always #(CYC/2) clk = ~clk;

  hb_bridge_ctrl uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .in_a_i   (in_a),
    .in_b_i   (in_b),
    .hiz_ni   (hiz_n),
    .pwr_en_i (pwr_en),
    .par_i    (par),
    .ocp_i    (ocp),
    .uvlo_i   (uvlo),
    .temp_i   (temp),
    .gate_o   (gate),
    .fault_no (fault_n),
    .warn_no  (warn_n)
  );

  // {par, a1, b1, a0, b0, expected gate}
  localparam logic [12:0] VEC [10] = '{
    {5'b00000, 8'hCC}, // R2
    {5'b00110, 8'h69}, // R3
    {5'b01001, 8'h96}, // R3
    {5'b01100, 8'h0C}, // R4
    {5'b00011, 8'hC0}, // R4
    {5'b01010, 8'h99}, // R3
    {5'b11001, 8'h3C}, // R8
    {5'b10111, 8'hC3}, // R8
    {5'b11110, 8'h33}, // R8
    {5'b00101, 8'h66}  // R3
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic toggle_hiz;
    hiz_n = 1'b0; step(1);
    hiz_n = 1'b1; step(1);
  endtask

  initial begin
    #(CYC * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(2);
    chk("R1 gates", gate, 8'h00);
    chk("R1 fault", {7'd0, fault_n}, 8'h01);
    chk("R1 warn",  {7'd0, warn_n},  8'h01);
    rst_n = 1'b1;
    step(1);

    for (int i = 0; i < 10; i++) begin
      {par, in_a[1], in_b[1], in_a[0], in_b[0]} = VEC[i][12:8];
      step(5);
      chk($sformatf("R2/R3/R4/R8 vec%0d", i), gate, VEC[i][7:0]);
    end
    par = 1'b0;

    // R7 dead time: leg A Q3 -> Q1 with Q3 on
    in_a = 2'b00; in_b = 2'b00; step(5);
    in_a[0] = 1'b1;
    step(1); chk("R7 edge1", {4'h0, gate[3:0]}, 8'h08);
    step(1); chk("R7 edge2", {4'h0, gate[3:0]}, 8'h08);
    step(1); chk("R7 edge3", {4'h0, gate[3:0]}, 8'h09);
    chk("R7 other bridge", {4'h0, gate[7:4]}, 8'h0C);
    // R7 no complement on: immediate
    in_b[0] = 1'b1; step(5);
    in_b[0] = 1'b0; step(1);
    chk("R7 immediate", {4'h0, gate[3:0]}, 8'h09);

    // back to CC
    in_a = 2'b00; step(5);
    // R5
    hiz_n = 1'b0; #1;
    chk("R5 same cycle", gate, 8'h00);
    in_a = 2'b01; step(2);
    chk("R5 held", gate, 8'h00);
    in_a = 2'b00; hiz_n = 1'b1; step(5);
    chk("R5 resume", gate, 8'hCC);

    // R6
    pwr_en = 1'b0; #1;
    chk("R6 gates", gate, 8'h00);
    chk("R6 fault", {7'd0, fault_n}, 8'h01);
    pwr_en = 1'b1; step(3);
    chk("R6 resume", gate, 8'hCC);

    // R9 / R10
    ocp = 1'b1; #1;
    chk("R9 gates", gate, 8'h00);
    chk("R9 fault", {7'd0, fault_n}, 8'h00);
    step(1); ocp = 1'b0; step(3);
    chk("R9 latched gates", gate, 8'h00);
    chk("R9 latched fault", {7'd0, fault_n}, 8'h00);
    toggle_hiz();
    chk("R10 cleared", {7'd0, fault_n}, 8'h01);
    step(1);
    chk("R10 resume", gate, 8'hCC);

    // R11 / R12
    temp = 8'd129; step(1);
    chk("R12 below", {7'd0, warn_n}, 8'h01);
    temp = 8'd130; step(1);
    chk("R12 warn", {7'd0, warn_n}, 8'h00);
    chk("R12 still running", gate, 8'hCC);
    temp = 8'd150; #1;
    chk("R11 gates", gate, 8'h00);
    chk("R11 fault", {7'd0, fault_n}, 8'h00);
    step(1);
    temp = 8'd140; step(1);
    toggle_hiz();
    chk("R11 hysteresis", {7'd0, fault_n}, 8'h00);
    step(1);
    chk("R11 hysteresis gates", gate, 8'h00);
    temp = 8'd125; step(1);
    chk("R12 released", {7'd0, warn_n}, 8'h01);
    toggle_hiz();
    chk("R11 cleared", {7'd0, fault_n}, 8'h01);
    step(1);
    chk("R11 resume", gate, 8'hCC);

    // R13
    uvlo = 1'b1; #1;
    chk("R13 gates", gate, 8'h00);
    chk("R13 fault", {7'd0, fault_n}, 8'h00);
    step(2);
    uvlo = 1'b0; step(2);
    chk("R13 auto fault", {7'd0, fault_n}, 8'h01);
    chk("R13 auto gates", gate, 8'hCC);

    // R1 reset mid-run
    rst_n = 1'b0; #1;
    chk("R1 async reset", gate, 8'h00);
    step(1);
    rst_n = 1'b1; step(1);

    summary();
  end

endmodule